// File: doc/BRIEF.md
# Program Counter and Control-Transfer Sequencer

This block owns the program counter and the stack pointer of a small 8-bit processor with a 16-bit address space. It carries out every control-transfer instruction: absolute jumps, jumps to a register-pair value, relative jumps, calls, returns, returns that re-enable interrupts, and restarts to fixed vectors. The surrounding decoder presents one instruction with a one-cycle `start` pulse. It also supplies the instruction's operand, the current register-pair value and the zero and carry flags. The block then stays busy for the exact number of machine cycles that the instruction costs. It uses a byte-wide memory port to push or pop the 16-bit return address.

A state machine steps through the instruction. Its states are IDLE (waiting), PUSH_HI and PUSH_LO (store the link address, high byte first), POP_LO and POP_HI (fetch the return address, low byte first), DELAY (burn the remaining internal cycles) and LAST (the final cycle, in which `done` is high). Its transitions are:

- IDLE to PUSH_HI on a push, to POP_LO on a pop, to DELAY when filler cycles remain, otherwise to LAST.
- PUSH_HI to PUSH_LO, and POP_LO to POP_HI.
- PUSH_LO or POP_HI to DELAY when filler cycles remain, otherwise to LAST.
- DELAY to itself until its counter reaches one, then to LAST.
- LAST to IDLE.

The program counter takes its new value at the clock edge that ends LAST.

Top module: `flow_ctrl_unit`

## Requirements
- R1: After reset the program counter is 0x0100, the stack pointer is 0xFFFE, and `busy`, `done` and `ime_set` are low.
- R2: When `cond_en` is 1, `cond_sel` picks the condition: 0 is zero flag clear, 1 is zero flag set, 2 is carry clear, 3 is carry set. When `cond_en` is 0 the transfer is always taken. `taken` reports the outcome while busy.
- R3: Absolute jump (op 0). When taken, PC becomes `operand` and the instruction takes 4 cycles. When not taken, PC becomes PC+3 and it takes 3 cycles.
- R4: Register jump (op 1). PC becomes `hl_in` in 1 cycle, and the condition is ignored.
- R5: Relative jump (op 2). When taken, PC becomes PC+2 plus the sign-extended `operand[7:0]` and it takes 3 cycles. When not taken, PC becomes PC+2 and it takes 2 cycles.
- R6: Call (op 3). When taken, the block writes PC+3 high byte at SP-1 and low byte at SP-2, SP drops by 2, PC becomes `operand`, and it takes 6 cycles. When not taken, nothing is written, SP is unchanged, PC becomes PC+3, and it takes 3 cycles.
- R7: Return (op 4). When taken, the block reads the low byte at SP and the high byte at SP+1, SP rises by 2, and PC becomes the value read. It takes 4 cycles unconditional and 5 cycles when conditional and taken. When not taken, PC becomes PC+1 and it takes 2 cycles.
- R8: Return with interrupt enable (op 5) always pops like an unconditional return and takes 4 cycles. `ime_set` pulses for one cycle, in the cycle where `done` is high. No other instruction raises `ime_set`.
- R9: Restart (op 6) pushes PC+1 like a call and sets PC to `operand[2:0]`×8, one of 0x00 through 0x38. It takes 4 cycles and ignores the condition.
- R10: Op code 7 is reserved. A start with op 7 is ignored: `busy` stays low and PC, SP and memory are unchanged.
- R11: A start while `busy` is high is ignored. The running instruction completes with its own result and cycle count.
- R12: `busy` is high for exactly the instruction's cycle count, counted from the cycle after the start, with `done` high only in the last of those cycles. PC changes only at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction launch pulse |
| op | input | 3 | Transfer kind (0 abs jump, 1 reg jump, 2 rel jump, 3 call, 4 return, 5 return+IE, 6 restart, 7 reserved) |
| cond_en | input | 1 | Conditional form select |
| cond_sel | input | 2 | Condition code |
| operand | input | 16 | Target address, offset in [7:0], or vector index in [2:0] |
| hl_in | input | 16 | Register-pair value for the register jump |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as `mem_rd` |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| taken | output | 1 | Condition outcome of the current instruction |
| ime_set | output | 1 | Interrupt-enable pulse from op 5 |

## Verification
A stuck or skipped state shows up directly at the ports. It changes the number of cycles `busy` stays high, and that count is compared with the expected cost for every op, condition and flag combination, so the error appears within the same instruction. A wrong stack pointer or push order corrupts the memory image and `sp` at once. It also turns into a wrong PC on the next return, at most a few instructions later, because the bench keeps a shadow image of memory and compares all of it after every instruction.

// File: rtl/flowcu_pkg.sv
package flowcu_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CYC_W  = 3;
    localparam int VEC_W  = 3;

    typedef enum logic [2:0] {
        OP_JP   = 3'd0,
        OP_JPR  = 3'd1,
        OP_JR   = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_RETI = 3'd5,
        OP_RST  = 3'd6,
        OP_RSVD = 3'd7
    } fop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_DELAY,
        ST_LAST
    } fst_e;

    typedef enum logic [1:0] {
        STK_NONE,
        STK_PUSH,
        STK_POP
    } stk_e;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              ime;
        stk_e              stk;
        logic [CYC_W-1:0]  total;
        logic [CYC_W-1:0]  filler;
        logic [ADDR_W-1:0] dest;
        logic [ADDR_W-1:0] link;
    } plan_t;
endpackage

// File: rtl/flowcu_decode.sv
module flowcu_decode
    import flowcu_pkg::*;
#(
    parameter int VEC_SHIFT = 3
) (
    input  fop_e              op,
    input  logic              cond_en,
    input  logic [1:0]        cond_sel,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic [ADDR_W-1:0] pc,
    input  logic              flag_z,
    input  logic              flag_c,
    output plan_t             plan
);
    localparam int SEXT_W = ADDR_W - BYTE_W;

    logic              cond_ok;
    logic              gated;
    logic [1:0]        len;
    logic [ADDR_W-1:0] next_pc;
    logic [ADDR_W-1:0] rel_pc;
    logic [ADDR_W-1:0] vec_pc;

    always_comb begin
        unique case (cond_sel)
            2'd0: cond_ok = !flag_z;
            2'd1: cond_ok = flag_z;
            2'd2: cond_ok = !flag_c;
            2'd3: cond_ok = flag_c;
        endcase
        gated = !cond_en || cond_ok;
    end

    always_comb begin
        case (op)
            OP_JP, OP_CALL: len = 2'd3;
            OP_JR:          len = 2'd2;
            default:        len = 2'd1;
        endcase
    end

    assign next_pc = pc + ADDR_W'(len);
    assign rel_pc  = next_pc + {{SEXT_W{operand[BYTE_W-1]}}, operand[BYTE_W-1:0]};
    assign vec_pc  = ADDR_W'(operand[VEC_W-1:0]) << VEC_SHIFT;

    always_comb begin
        plan        = '0;
        plan.valid  = 1'b1;
        plan.link   = next_pc;
        plan.stk    = STK_NONE;
        case (op)
            OP_JP: begin
                plan.taken = gated;
                plan.total = gated ? 3'd4 : 3'd3;
                plan.dest  = operand;
            end
            OP_JPR: begin
                plan.taken = 1'b1;
                plan.total = 3'd1;
                plan.dest  = hl_in;
            end
            OP_JR: begin
                plan.taken = gated;
                plan.total = gated ? 3'd3 : 3'd2;
                plan.dest  = rel_pc;
            end
            OP_CALL: begin
                plan.taken = gated;
                plan.total = gated ? 3'd6 : 3'd3;
                plan.dest  = operand;
                plan.stk   = gated ? STK_PUSH : STK_NONE;
            end
            OP_RET: begin
                plan.taken = gated;
                plan.total = !gated ? 3'd2 : (cond_en ? 3'd5 : 3'd4);
                plan.stk   = gated ? STK_POP : STK_NONE;
            end
            OP_RETI: begin
                plan.taken = 1'b1;
                plan.total = 3'd4;
                plan.stk   = STK_POP;
                plan.ime   = 1'b1;
            end
            OP_RST: begin
                plan.taken = 1'b1;
                plan.total = 3'd4;
                plan.dest  = vec_pc;
                plan.stk   = STK_PUSH;
            end
            default: begin
                plan.valid = 1'b0;
                plan.total = 3'd1;
            end
        endcase
        if (!plan.taken) begin
            plan.dest = next_pc;
        end
        plan.filler = plan.total - 3'd1 - ((plan.stk != STK_NONE) ? 3'd2 : 3'd0);
    end
endmodule

// File: rtl/flowcu_seq.sv
module flowcu_seq
    import flowcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  stk_e             stk_in,
    input  logic [CYC_W-1:0] fill_in,
    output fst_e             state,
    output logic             busy,
    output logic             done,
    output logic             push_hi,
    output logic             push_lo,
    output logic             pop_lo,
    output logic             pop_hi
);
    fst_e             state_nx;
    logic [CYC_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) begin
                    if (stk_in == STK_PUSH)      state_nx = ST_PUSH_HI;
                    else if (stk_in == STK_POP)  state_nx = ST_POP_LO;
                    else if (fill_in != '0)      state_nx = ST_DELAY;
                    else                         state_nx = ST_LAST;
                end
            end
            ST_PUSH_HI: state_nx = ST_PUSH_LO;
            ST_POP_LO:  state_nx = ST_POP_HI;
            ST_PUSH_LO,
            ST_POP_HI:  state_nx = (cnt != '0) ? ST_DELAY : ST_LAST;
            ST_DELAY:   state_nx = (cnt == CYC_W'(1)) ? ST_LAST : ST_DELAY;
            ST_LAST:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (launch && state == ST_IDLE) begin
                cnt <= fill_in;
            end else if (state == ST_DELAY) begin
                cnt <= cnt - CYC_W'(1);
            end
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_LAST);
        push_hi = (state == ST_PUSH_HI);
        push_lo = (state == ST_PUSH_LO);
        pop_lo  = (state == ST_POP_LO);
        pop_hi  = (state == ST_POP_HI);
    end

    // R12
    delay_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DELAY |-> cnt != '0);

    // R12
    last_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LAST |=> state == ST_IDLE);
endmodule

// File: rtl/flowcu_stack.sv
module flowcu_stack
    import flowcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_RESET = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_hi,
    input  logic              push_lo,
    input  logic              pop_lo,
    input  logic              pop_hi,
    input  logic [ADDR_W-1:0] link,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] popped
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        if (push_hi || push_lo) begin
            mem_addr  = sp - ADDR_W'(1);
            mem_wr    = 1'b1;
            mem_wdata = push_hi ? link[ADDR_W-1:BYTE_W] : link[BYTE_W-1:0];
        end else if (pop_lo || pop_hi) begin
            mem_addr = sp;
            mem_rd   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp   <= SP_RESET;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (push_hi || push_lo) begin
                sp <= sp - ADDR_W'(1);
            end else if (pop_lo || pop_hi) begin
                sp <= sp + ADDR_W'(1);
            end
            if (pop_lo) lo_q <= mem_rdata;
            if (pop_hi) hi_q <= mem_rdata;
        end
    end

    assign popped = {hi_q, lo_q};

    // R6
    push_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_lo |-> mem_addr == $past(mem_addr) - ADDR_W'(1));

    // R7
    pop_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_hi |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
    import flowcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET  = 16'h0100,
    parameter logic [ADDR_W-1:0] SP_RESET  = 16'hFFFE,
    parameter int                VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              cond_en,
    input  logic [1:0]        cond_sel,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic              ime_set
);
    plan_t             plan_d;
    plan_t             plan_q;
    fst_e              state;
    logic              launch;
    logic              push_hi, push_lo, pop_lo, pop_hi;
    logic [ADDR_W-1:0] popped;
    logic [CYC_W-1:0]  busy_cnt;

    flowcu_decode #(.VEC_SHIFT(VEC_SHIFT)) u_decode (
        .op       (fop_e'(op)),
        .cond_en  (cond_en),
        .cond_sel (cond_sel),
        .operand  (operand),
        .hl_in    (hl_in),
        .pc       (pc),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .plan     (plan_d)
    );

    assign launch = start && !busy && plan_d.valid;

    flowcu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .stk_in  (plan_d.stk),
        .fill_in (plan_d.filler),
        .state   (state),
        .busy    (busy),
        .done    (done),
        .push_hi (push_hi),
        .push_lo (push_lo),
        .pop_lo  (pop_lo),
        .pop_hi  (pop_hi)
    );

    flowcu_stack #(.SP_RESET(SP_RESET)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_hi   (push_hi),
        .push_lo   (push_lo),
        .pop_lo    (pop_lo),
        .pop_hi    (pop_hi),
        .link      (plan_q.link),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wr    (mem_wr),
        .mem_rd    (mem_rd),
        .popped    (popped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= PC_RESET;
            plan_q   <= '0;
            busy_cnt <= '0;
        end else begin
            if (launch) begin
                plan_q <= plan_d;
            end
            if (done) begin
                pc <= (plan_q.stk == STK_POP) ? popped : plan_q.dest;
            end
            if (busy && !done) busy_cnt <= busy_cnt + CYC_W'(1);
            else               busy_cnt <= '0;
        end
    end

    always_comb begin
        taken   = plan_q.taken;
        ime_set = done && plan_q.ime;
    end

    // R12
    cycle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt + CYC_W'(1)) == plan_q.total);

    // R12
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> $stable(pc));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R8
    ime_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ime_set |=> !ime_set);
endmodule

// File: tb/flow_ctrl_unit_bench.sv
`timescale 1ns/1ps
module flow_ctrl_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        cond_en = 1'b0;
    logic [1:0]  cond_sel = '0;
    logic [15:0] operand = '0;
    logic [15:0] hl_in = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_wr, mem_rd;
    logic [15:0] pc, sp;
    logic        busy, done, taken, ime_set;

    logic [7:0]  mem    [256];
    logic [7:0]  shadow [256];
    logic [15:0] pc_m, sp_m, seed;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    flow_ctrl_unit u_flow_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
        .cond_sel(cond_sel), .operand(operand), .hl_in(hl_in), .flag_z(flag_z),
        .flag_c(flag_c), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd), .pc(pc), .sp(sp),
        .busy(busy), .done(done), .taken(taken), .ime_set(ime_set)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr[7:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i] && bad < 0) bad = i;
        if (bad < 0) check(1'b1, req, "memory image", 0, 0);
        else check(1'b0, req, "memory image", 32'(mem[bad]), 32'(shadow[bad]));
    endtask

    task automatic run_one(input logic [2:0] o, input logic ce, input logic [1:0] cs,
                           input logic [15:0] opnd, input logic [15:0] hl,
                           input logic z, input logic c);
        logic        ok_c, g, push, pop, ime_seen, tk_seen;
        logic [15:0] nxt, exp_pc, a;
        int          exp_cyc, n;
        string       req;
        case (cs)
            2'd0: ok_c = !z;
            2'd1: ok_c = z;
            2'd2: ok_c = !c;
            default: ok_c = c;
        endcase
        g = !ce || ok_c;
        push = 0; pop = 0;
        case (o)
            3'd0: begin req = "R3"; nxt = pc_m + 3; exp_pc = g ? opnd : nxt; exp_cyc = g ? 4 : 3; end
            3'd1: begin req = "R4"; g = 1; nxt = pc_m + 1; exp_pc = hl; exp_cyc = 1; end
            3'd2: begin req = "R5"; nxt = pc_m + 2;
                        exp_pc = g ? nxt + {{8{opnd[7]}}, opnd[7:0]} : nxt; exp_cyc = g ? 3 : 2; end
            3'd3: begin req = "R6"; nxt = pc_m + 3; exp_pc = g ? opnd : nxt; exp_cyc = g ? 6 : 3; push = g; end
            3'd4: begin req = "R7"; nxt = pc_m + 1; exp_pc = nxt; exp_cyc = !g ? 2 : (ce ? 5 : 4); pop = g; end
            3'd5: begin req = "R8"; g = 1; nxt = pc_m + 1; exp_pc = nxt; exp_cyc = 4; pop = 1; end
            default: begin req = "R9"; g = 1; nxt = pc_m + 1; exp_pc = {10'd0, opnd[2:0], 3'd0};
                           exp_cyc = 4; push = 1; end
        endcase
        if (push) begin
            a = sp_m - 16'd1; shadow[a[7:0]] = nxt[15:8];
            a = sp_m - 16'd2; shadow[a[7:0]] = nxt[7:0];
            sp_m = sp_m - 16'd2;
        end
        if (pop) begin
            a = sp_m + 16'd1;
            exp_pc = {shadow[a[7:0]], shadow[sp_m[7:0]]};
            sp_m = sp_m + 16'd2;
        end
        @(negedge clk);
        op = o; cond_en = ce; cond_sel = cs; operand = opnd; hl_in = hl;
        flag_z = z; flag_c = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; ime_seen = 0; tk_seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (busy) begin n++; tk_seen = taken; end
            if (ime_set) ime_seen = 1;
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        check(n == exp_cyc, req, "R12 cycle count", 32'(n), 32'(exp_cyc));
        check(pc == exp_pc, req, "pc", 32'(pc), 32'(exp_pc));
        check(sp == sp_m, req, "sp", 32'(sp), 32'(sp_m));
        check(tk_seen == g, "R2", "taken", 32'(tk_seen), 32'(g));
        check(ime_seen == (o == 3'd5), "R8", "ime_set", 32'(ime_seen), 32'(o == 3'd5));
        check_mem(req);
        pc_m = exp_pc;
    endtask

    function automatic logic [15:0] nxt_seed(input logic [15:0] s);
        return s * 16'd25173 + 16'd13849;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
        pc_m = 16'h0100; sp_m = 16'hFFFE; seed = 16'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pc == 16'h0100, "R1", "pc", 32'(pc), 32'h0100);
        check(sp == 16'hFFFE, "R1", "sp", 32'(sp), 32'hFFFE);
        check(!busy && !done && !ime_set, "R1", "busy/done/ime", 32'({busy, done, ime_set}), 0);

        // R10 reserved op ignored
        @(negedge clk);
        op = 3'd7; operand = 16'h4444; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            logic seen = 0;
            for (int k = 0; k < 4; k++) begin
                if (busy) seen = 1;
                @(negedge clk);
            end
            check(!seen, "R10", "busy on reserved op", 32'(seen), 0);
        end
        check(pc == pc_m, "R10", "pc after reserved op", 32'(pc), 32'(pc_m));
        check(sp == sp_m, "R10", "sp after reserved op", 32'(sp), 32'(sp_m));
        check_mem("R10");

        // Sweep every op, form, condition and flag pattern (R2..R9)
        for (int o = 0; o < 7; o++)
            for (int ce = 0; ce < 2; ce++)
                for (int cs = 0; cs < 4; cs++)
                    for (int f = 0; f < 4; f++) begin
                        seed = nxt_seed(seed);
                        run_one(3'(o), 1'(ce), 2'(cs), seed, ~seed ^ 16'h0F0F, f[0], f[1]);
                    end

        // R5 offset extremes
        run_one(3'd2, 1'b0, 2'd0, 16'h0080, 16'h0, 1'b0, 1'b0);
        run_one(3'd2, 1'b0, 2'd0, 16'h007F, 16'h0, 1'b0, 1'b0);
        run_one(3'd2, 1'b0, 2'd0, 16'hFF00, 16'h0, 1'b0, 1'b0);
        // R9 every vector, then unwind with R7 returns
        for (int v = 0; v < 8; v++) run_one(3'd6, 1'b0, 2'd0, 16'(v) | 16'hA5A0, 16'h0, 1'b0, 1'b0);
        for (int v = 0; v < 8; v++) run_one(3'd4, 1'b0, 2'd0, 16'h0, 16'h0, 1'b0, 1'b0);
        // R6 call followed by R8 return: lands after the call
        run_one(3'd3, 1'b0, 2'd0, 16'h3210, 16'h0, 1'b0, 1'b0);
        run_one(3'd5, 1'b0, 2'd0, 16'h0, 16'h0, 1'b0, 1'b0);

        // R11 start during busy is ignored
        @(negedge clk);
        op = 3'd0; cond_en = 1'b0; operand = 16'h2468; start = 1'b1;
        @(negedge clk);
        op = 3'd1; hl_in = 16'h1357;
        begin
            int n = 0;
            for (int k = 0; k < 20; k++) begin
                if (busy) n++;
                if (done) break;
                @(negedge clk);
                start = 1'b0;
            end
            start = 1'b0;
            @(negedge clk);
            check(n == 4, "R11", "cycle count with extra start", 32'(n), 4);
            check(pc == 16'h2468, "R11", "pc with extra start", 32'(pc), 32'h2468);
            @(negedge clk);
            check(!busy, "R11", "idle after finish", 32'(busy), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule